// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers sixteen interrupt sources for a small microcontroller core. Each source owns an enable bit, a one-bit priority level and a pending flag. All of them sit in byte-wide registers behind a simple write/read port. From the enabled pending requests the block picks one winner. It raises a request to the CPU, together with the winner's index and a vector address.

The CPU pulses `irq_ack` when it starts servicing the offered request. That pulse clears the source's pending flag and records the level now in service. The CPU pulses `irq_ret` when the service routine ends. A request at level 1 may interrupt a level-0 routine, but nothing interrupts a level-1 routine. The depth of nested service can be read back.

The vector base is a byte register scaled by 256. It can be changed only while a separate key register holds 5Ah.

Register map (`reg_addr`):
- 0: control. Bit 7 is the global enable; the other bits read 0.
- 1 and 2: enables for sources 7..0 and 15..8.
- 3 and 4: priorities for sources 7..0 and 15..8.
- 5 and 6: pending flags for sources 7..0 and 15..8.
- 7: key register.
- 8: vector base.
- 9: nesting depth, read-only.
- 10 to 15: read as 0.

Top module: `irq_ctrl_2lvl`

## Requirements
- R1: After reset every register reads 00h, `irq_req` is 0 and `nest_lvl` is 0.
- R2: While control bit 7 (address 0) is 0, `irq_req` stays 0 whatever the enables and pending flags hold.
- R3: A pending flag is set in the cycle after `src_evt[i]` is high. A register write clears every flag whose data bit is 0, and data bits at 1 leave their flags unchanged. If a clear and a set hit one flag in the same cycle, the flag ends at 1.
- R4: An `irq_ack` pulse while `irq_req` is 1 clears the flag of `irq_id`, unless that source sets it again in the same cycle. It also raises `nest_lvl` by one, saturating at 4. An `irq_ack` pulse while `irq_req` is 0 has no effect.
- R5: An `irq_ret` pulse lowers `nest_lvl` by one and ends the innermost active level, which is level 1 if it is active and level 0 otherwise. At depth 0 it has no effect.
- R6: Among sources that are pending and enabled, any source with priority bit 1 beats every source with priority bit 0. Within one level, the lowest index wins and is shown on `irq_id`.
- R7: `irq_req` is 1 only when a winner exists and one of two cases holds: no level is in service, or the winner is at level 1 while level 1 is not in service.
- R8: `irq_vec` equals 256 times the base register plus 8 times `irq_id`.
- R9: A write to the base register (address 8) takes effect only while the key register (address 7) holds 5Ah. The key register accepts any write.
- R10: Address 9 reads `nest_lvl` in bits 2:0, and writes to it are ignored.
- R11: Reads follow the register map above, and unused addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 16 | Per-source event, sampled each cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_ack | input | 1 | CPU starts servicing the offered request |
| irq_ret | input | 1 | CPU finished the innermost routine |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_id | output | 4 | Index of the winning source |
| irq_vec | output | 16 | Vector address of the winner |
| nest_lvl | output | 3 | Current nesting depth |

## Verification
On every cycle the assertions check four things:
- the global gate, and that an offered request is always enabled and pending;
- the vector's split into base and index;
- that the base holds when the key is wrong;
- the depth's step up on an accepted acknowledge, its floor at zero and its ceiling.

The winner choice between levels and indices, the preemption rule and the outcome of a clear and a set in the same cycle are shown only by the bench. The bench drives directed scenarios and random traffic, and compares every output against a reference model that it steps along with the design.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 8;
  localparam logic [7:0] UNLOCK_KEY = 8'h5A;

  // Register map; byte-pair registers (low then high) assume sixteen sources.
  typedef enum logic [REG_AW-1:0] {
    A_CTL    = 4'd0,
    A_EN_LO  = 4'd1,
    A_EN_HI  = 4'd2,
    A_PRI_LO = 4'd3,
    A_PRI_HI = 4'd4,
    A_PND_LO = 4'd5,
    A_PND_HI = 4'd6,
    A_KEY    = 4'd7,
    A_BASE   = 4'd8,
    A_LVL    = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NSRC-1:0]   ack_clr,
  output logic              gen_q,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   pri_q,
  output logic [NSRC-1:0]   pend_q,
  output logic [REG_DW-1:0] key_q,
  output logic [REG_DW-1:0] base_q
);
  localparam int unsigned NBYTE = NSRC / 8;

  logic              gen_d;
  logic [NSRC-1:0]   en_d, pri_d, pend_d, sw_clr;
  logic [REG_DW-1:0] key_d, base_d;
  logic              base_open;

  assign base_open = (key_q == UNLOCK_KEY);

  always_comb begin
    gen_d  = gen_q;
    en_d   = en_q;
    pri_d  = pri_q;
    key_d  = key_q;
    base_d = base_q;
    sw_clr = '0;
    if (reg_wr && reg_addr == A_CTL)  gen_d = reg_wdata[7];
    if (reg_wr && reg_addr == A_KEY)  key_d = reg_wdata;
    if (reg_wr && reg_addr == A_BASE && base_open) base_d = reg_wdata;
    for (int b = 0; b < NBYTE; b++) begin
      if (reg_wr && reg_addr == REG_AW'(int'(A_EN_LO) + b))  en_d[b*8 +: 8]   = reg_wdata;
      if (reg_wr && reg_addr == REG_AW'(int'(A_PRI_LO) + b)) pri_d[b*8 +: 8]  = reg_wdata;
      if (reg_wr && reg_addr == REG_AW'(int'(A_PND_LO) + b)) sw_clr[b*8 +: 8] = ~reg_wdata;
    end
    // hardware event has the last word over any clear
    pend_d = (pend_q & ~sw_clr & ~ack_clr) | src_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
      pend_q <= '0;
      key_q  <= '0;
      base_q <= '0;
    end else begin
      gen_q  <= gen_d;
      en_q   <= en_d;
      pri_q  <= pri_d;
      pend_q <= pend_d;
      key_q  <= key_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NSRC = 16,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input  logic            gen,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] pri,
  input  logic [NSRC-1:0] pend,
  output logic            win_vld,
  output logic            win_lvl,
  output logic [IDW-1:0]  win_id
);
  logic [NSRC-1:0] elig, hi_set, cand;

  always_comb begin
    elig    = pend & en & {NSRC{gen}};
    hi_set  = elig & pri;
    win_lvl = |hi_set;
    win_vld = |elig;
    cand    = win_lvl ? hi_set : elig;
    win_id  = '0;
    // scan downward so the lowest set index is the last assignment
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) win_id = IDW'(i);
    end
  end
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
  parameter int unsigned MAX_NEST = 4,
  localparam int unsigned LVW = $clog2(MAX_NEST + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_ok,
  input  logic           ret,
  input  logic           win_lvl,
  output logic [LVW-1:0] nest_q,
  output logic           svc_act,
  output logic           svc_lvl
);
  logic [1:0]     insvc_q, insvc_d;
  logic [LVW-1:0] nest_d;
  logic           ret_ok;

  assign ret_ok  = ret && (nest_q != '0);
  assign svc_act = |insvc_q;
  assign svc_lvl = insvc_q[1];

  always_comb begin
    insvc_d = insvc_q;
    if (ret_ok) begin
      if (insvc_q[1]) insvc_d[1] = 1'b0;
      else            insvc_d[0] = 1'b0;
    end
    if (ack_ok) insvc_d[win_lvl] = 1'b1;

    nest_d = nest_q;
    if (ack_ok && !ret_ok && nest_q != LVW'(MAX_NEST)) nest_d = nest_q + 1'b1;
    else if (ret_ok && !ack_ok)                        nest_d = nest_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insvc_q <= '0;
      nest_q  <= '0;
    end else begin
      insvc_q <= insvc_d;
      nest_q  <= nest_d;
    end
  end
endmodule

// File: rtl/irq_ctrl_2lvl.sv
module irq_ctrl_2lvl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned MAX_NEST = 4,
  localparam int unsigned IDW = $clog2(NSRC),
  localparam int unsigned LVW = $clog2(MAX_NEST + 1),
  localparam int unsigned VW  = 2 * REG_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [IDW-1:0]    irq_id,
  output logic [VW-1:0]     irq_vec,
  output logic [LVW-1:0]    nest_lvl
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              gen_q;
  logic [NSRC-1:0]   en_q, pri_q, pend_q, ack_clr;
  logic [REG_DW-1:0] key_q, base_q;
  logic              win_vld, win_lvl, svc_act, svc_lvl, ack_ok;
  logic [IDW-1:0]    win_id;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_regfile #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .src_evt(src_evt), .ack_clr(ack_clr),
    .gen_q(gen_q), .en_q(en_q), .pri_q(pri_q), .pend_q(pend_q),
    .key_q(key_q), .base_q(base_q)
  );

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .gen(gen_q), .en(en_q), .pri(pri_q), .pend(pend_q),
    .win_vld(win_vld), .win_lvl(win_lvl), .win_id(win_id)
  );

  irq_nest_tracker #(.MAX_NEST(MAX_NEST)) u_nest (
    .clk(clk), .rst_n(rst_int_n), .ack_ok(ack_ok), .ret(irq_ret),
    .win_lvl(win_lvl), .nest_q(nest_lvl), .svc_act(svc_act), .svc_lvl(svc_lvl)
  );

  assign irq_req = win_vld && (!svc_act || (win_lvl && !svc_lvl));
  assign ack_ok  = irq_ack && irq_req;
  assign ack_clr = ack_ok ? (NSRC'(1) << win_id) : '0;
  assign irq_id  = win_id;
  assign irq_vec = {base_q, {REG_DW{1'b0}}} + (VW'(win_id) << 3);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL:    reg_rdata = {gen_q, 7'b0};
      A_EN_LO:  reg_rdata = en_q[7:0];
      A_EN_HI:  reg_rdata = en_q[15:8];
      A_PRI_LO: reg_rdata = pri_q[7:0];
      A_PRI_HI: reg_rdata = pri_q[15:8];
      A_PND_LO: reg_rdata = pend_q[7:0];
      A_PND_HI: reg_rdata = pend_q[15:8];
      A_KEY:    reg_rdata = key_q;
      A_BASE:   reg_rdata = base_q;
      A_LVL:    reg_rdata = REG_DW'(nest_lvl);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NSRC     = 16,
  parameter int unsigned MAX_NEST = 4,
  localparam int unsigned IDW = $clog2(NSRC),
  localparam int unsigned LVW = $clog2(MAX_NEST + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gen,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] src_evt,
  input logic [7:0]      key,
  input logic [7:0]      base,
  input logic            irq_req,
  input logic [IDW-1:0]  irq_id,
  input logic [15:0]     irq_vec,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic [LVW-1:0]  nest_lvl
);
  assert_global_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !irq_req);

  assert_req_source_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_id] && en[irq_id]));

  assert_ack_clears_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !src_evt[irq_id]) |=> !pend[$past(irq_id)]);

  assert_ack_deepens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_ret && nest_lvl < LVW'(MAX_NEST))
      |=> nest_lvl == $past(nest_lvl) + 1'b1);

  assert_ret_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && nest_lvl == '0 && !(irq_ack && irq_req)) |=> nest_lvl == '0);

  assert_depth_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nest_lvl <= LVW'(MAX_NEST));

  assert_vector_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[15:8] == base && irq_vec[7:3] == 5'(irq_id) && irq_vec[2:0] == 3'b000));

  assert_base_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key != 8'h5A) |=> $stable(base));
endmodule

bind irq_ctrl_2lvl irq_ctrl_chk #(.NSRC(NSRC), .MAX_NEST(MAX_NEST)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen(gen_q), .en(en_q), .pend(pend_q),
  .src_evt(src_evt), .key(key_q), .base(base_q), .irq_req(irq_req),
  .irq_id(irq_id), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret),
  .nest_lvl(nest_lvl)
);

// File: tb/irq_ctrl_2lvl_bench.sv
module irq_ctrl_2lvl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_id;
  logic [15:0] irq_vec;
  logic [2:0]  nest_lvl;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic        m_gen;
  logic [15:0] m_en, m_pri, m_pend;
  logic [7:0]  m_key, m_base;
  logic [1:0]  m_insvc;
  logic [2:0]  m_nest;
  logic        e_req, e_lvl;
  logic [3:0]  e_id;

  irq_ctrl_2lvl u_irq_ctrl_2lvl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .irq_id(irq_id), .irq_vec(irq_vec), .nest_lvl(nest_lvl)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_rd(input logic [3:0] a);
    case (a)
      4'd0: return {m_gen, 7'b0};
      4'd1: return m_en[7:0];
      4'd2: return m_en[15:8];
      4'd3: return m_pri[7:0];
      4'd4: return m_pri[15:8];
      4'd5: return m_pend[7:0];
      4'd6: return m_pend[15:8];
      4'd7: return m_key;
      4'd8: return m_base;
      4'd9: return {5'b0, m_nest};
      default: return 8'h00;
    endcase
  endfunction

  // winner: {valid, level, id}
  function automatic logic [5:0] f_win();
    logic [15:0] live, pool;
    logic        found;
    logic [3:0]  id;
    live  = m_gen ? (m_pend & m_en) : 16'h0;
    pool  = ((live & m_pri) != 0) ? (live & m_pri) : live;
    found = 1'b0;
    id    = 4'd0;
    for (int i = 0; i < 16; i++) begin
      if (!found && pool[i]) begin
        found = 1'b1;
        id    = 4'(i);
      end
    end
    return {found, (live & m_pri) != 0, id};
  endfunction

  task automatic model_reset();
    m_gen = 0; m_en = 0; m_pri = 0; m_pend = 0; m_key = 0; m_base = 0;
    m_insvc = 0; m_nest = 0;
  endtask

  // called right after a falling edge
  task automatic cyc(input string tag, input logic [15:0] evt, input logic wr,
                     input logic [3:0] addr, input logic [7:0] wd,
                     input logic ack, input logic ret);
    logic [5:0]  w;
    logic        ack_ok, ret_ok;
    logic [15:0] clr;
    logic        n_gen;
    logic [15:0] n_en, n_pri, n_pend;
    logic [7:0]  n_key, n_base;
    logic [1:0]  n_insvc;
    logic [2:0]  n_nest;
    src_evt = evt; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    irq_ack = ack; irq_ret = ret;
    #1;
    w     = f_win();
    e_id  = w[3:0];
    e_lvl = w[4];
    e_req = w[5] && (m_insvc == 2'b00 || (e_lvl && !m_insvc[1]));
    chk({tag, " R7 irq_req"}, 16'(irq_req), 16'(e_req));
    if (e_req) begin
      chk({tag, " R6 irq_id"}, 16'(irq_id), 16'(e_id));
      chk({tag, " R8 irq_vec"}, irq_vec, {m_base, 8'h00} + 16'(e_id) * 16'd8);
    end
    chk({tag, " R4 R5 nest_lvl"}, 16'(nest_lvl), 16'(m_nest));
    chk({tag, " R11 reg_rdata"}, 16'(reg_rdata), 16'(f_rd(addr)));
    // next model state
    ack_ok = ack && e_req;
    ret_ok = ret && (m_nest != 0);
    n_gen = m_gen; n_en = m_en; n_pri = m_pri; n_key = m_key; n_base = m_base;
    clr = ack_ok ? (16'h1 << e_id) : 16'h0;
    if (wr) begin
      case (addr)
        4'd0: n_gen = wd[7];
        4'd1: n_en[7:0] = wd;
        4'd2: n_en[15:8] = wd;
        4'd3: n_pri[7:0] = wd;
        4'd4: n_pri[15:8] = wd;
        4'd5: clr[7:0] = clr[7:0] | ~wd;
        4'd6: clr[15:8] = clr[15:8] | ~wd;
        4'd7: n_key = wd;
        4'd8: if (m_key == 8'h5A) n_base = wd;
        default: ;
      endcase
    end
    n_pend  = (m_pend & ~clr) | evt;
    n_insvc = m_insvc;
    if (ret_ok) begin
      if (n_insvc[1]) n_insvc[1] = 1'b0;
      else            n_insvc[0] = 1'b0;
    end
    if (ack_ok) n_insvc[e_lvl] = 1'b1;
    n_nest = m_nest;
    if (ack_ok && !ret_ok && m_nest != 3'd4) n_nest = m_nest + 3'd1;
    else if (ret_ok && !ack_ok)              n_nest = m_nest - 3'd1;
    @(posedge clk);
    m_gen = n_gen; m_en = n_en; m_pri = n_pri; m_pend = n_pend;
    m_key = n_key; m_base = n_base; m_insvc = n_insvc; m_nest = n_nest;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input logic [3:0] addr);
    cyc(tag, 16'h0, 1'b0, addr, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic wr8(input string tag, input logic [3:0] addr, input logic [7:0] d);
    cyc(tag, 16'h0, 1'b1, addr, d, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h1A2B3C);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values through every address
    for (int a = 0; a < 16; a++) idle("R1", 4'(a));
    chk("R1 irq_req after reset", 16'(irq_req), 16'h0);

    // R2: sources enabled and pending, global gate off
    wr8("R2", 4'd1, 8'h08);
    wr8("R2", 4'd2, 8'h02);
    cyc("R2", 16'h0208, 1'b0, 4'd5, 8'h00, 1'b0, 1'b0);
    idle("R2", 4'd6);
    chk("R2 gate off", 16'(irq_req), 16'h0);
    wr8("R2", 4'd0, 8'h80);
    idle("R6", 4'd0);
    chk("R6 lowest index same level", 16'(irq_id), 16'd3);

    // R6: level 1 beats lower index at level 0
    wr8("R6", 4'd4, 8'h02);
    idle("R6", 4'd4);
    chk("R6 level one wins", 16'(irq_id), 16'd9);

    // R9: base locked without key, open with key
    wr8("R9", 4'd8, 8'h40);
    idle("R9", 4'd8);
    chk("R9 base locked", 16'(reg_rdata), 16'h00);
    wr8("R9", 4'd7, 8'h5A);
    wr8("R9", 4'd8, 8'h12);
    idle("R8", 4'd8);
    chk("R8 vector", irq_vec, 16'h1248);
    wr8("R9", 4'd7, 8'h00);

    // R4 / R7: acknowledge level-1 source, lower level must wait
    cyc("R4", 16'h0, 1'b0, 4'd6, 8'h00, 1'b1, 1'b0);
    idle("R4", 4'd6);
    chk("R4 flag cleared", 16'(reg_rdata), 16'h00);
    chk("R4 depth one", 16'(nest_lvl), 16'd1);
    chk("R7 no preempt by lower", 16'(irq_req), 16'h0);
    cyc("R5", 16'h0, 1'b0, 4'd9, 8'h00, 1'b0, 1'b1);
    idle("R7", 4'd9);
    chk("R7 resumes level zero", 16'(irq_req), 16'h1);
    cyc("R4", 16'h0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b0);
    cyc("R7", 16'h0200, 1'b0, 4'd9, 8'h00, 1'b0, 1'b0);
    idle("R7", 4'd9);
    chk("R7 preempt by higher", 16'(irq_req), 16'h1);
    cyc("R4", 16'h0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b0);
    idle("R4", 4'd9);
    chk("R4 depth two", 16'(nest_lvl), 16'd2);
    chk("R10 depth readable", 16'(reg_rdata), 16'd2);
    cyc("R4", 16'h0, 1'b0, 4'd9, 8'h00, 1'b1, 1'b0);
    chk("R4 ack without request ignored", 16'(nest_lvl), 16'd2);
    wr8("R10", 4'd9, 8'hFF);
    idle("R10", 4'd9);
    chk("R10 write ignored", 16'(reg_rdata), 16'd2);
    for (int k = 0; k < 3; k++) cyc("R5", 16'h0, 1'b0, 4'd9, 8'h00, 1'b0, 1'b1);
    chk("R5 floor at zero", 16'(nest_lvl), 16'd0);

    // R3: pending flag write rules
    wr8("R3", 4'd1, 8'h00);
    cyc("R3", 16'h0020, 1'b0, 4'd5, 8'h00, 1'b0, 1'b0);
    wr8("R3", 4'd5, 8'hFF);
    idle("R3", 4'd5);
    chk("R3 write one no effect", 16'(reg_rdata), 16'h20);
    cyc("R3", 16'h0020, 1'b1, 4'd5, 8'h00, 1'b0, 1'b0);
    idle("R3", 4'd5);
    chk("R3 set beats clear", 16'(reg_rdata), 16'h20);
    wr8("R3", 4'd5, 8'h00);
    idle("R3", 4'd5);
    chk("R3 write zero clears", 16'(reg_rdata), 16'h00);

    // random traffic against the model
    for (int n = 0; n < 6000; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 11));
      d = 8'($urandom);
      if (a == 4'd7 && $urandom_range(0, 1) == 1) d = 8'h5A;
      if (a == 4'd0 && $urandom_range(0, 3) != 0) d[7] = 1'b1;
      cyc("RANDOM", 16'($urandom & $urandom & $urandom),
          $urandom_range(0, 3) == 0, a, d,
          $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule